// File: doc/BRIEF.md
# PCI Type-0 Configuration Address Translator

This block sits between a CPU-side register window and the configuration port of a PCI root bus. Each CPU access that lands in the 512 KiB configuration window carries a window offset. The block takes the low 16 bits of that offset and joins them to a 16-bit page value held in a programmable map register, which gives a 32-bit working address. The upper part of the working address, from bit 11 up, is a one-hot device-select field. The block encodes the lowest set bit of that field into a binary device number. It then builds a standard configuration address from the device number, the function number, the register number and a static bus number. It hands that address, with the access strobes, to a downstream configuration port one clock later.

Bit 16 of the map register selects a non-type-0 mode. In that mode nothing is forwarded: writes are dropped, and reads are answered locally with all ones for the access size. A type-0 access whose device-select field is all zero is an error. It raises a sticky error flag, goes no further, and a read returns all ones. Every access that is forwarded also sends a one-cycle pulse that clears the received-master-abort and received-target-abort bits in the bridge's own status word. An access whose two lowest address bits are not zero is still legal, but it is marked as a sub-word access.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The map register (17 bits) resets to zero. A write through `map_we` takes effect for every access that is accepted after the write cycle.
- R2: The working address is the map register bits [15:0] placed in bits [31:16], joined to offset bits [15:0] in bits [15:0]. Offset bits [18:16] have no effect on the result.
- R3: The device number is the index of the lowest set bit of working-address bits [31:11]. Working-address bit 11+n gives device n. Set bits above the lowest one are ignored.
- R4: The function number is working-address bits [10:8]. The register number is working-address bits [7:0], including its two lowest bits.
- R5: The forwarded configuration address has bit 31 = 1, bits [30:24] = 0, bus number [23:16] taken from `bus_num`, device [15:11], function [10:8] and register [7:0].
- R6: An accepted request goes through as a one-cycle `cfg_valid` in the next clock cycle. That cycle also carries the write flag, the size code and the write data. Outputs are zero out of reset.
- R7: When map bit 16 is 1, no access is forwarded. A write gets no response. A read gives `rsp_valid` in the next cycle, with `rsp_data` set by the size code: 0 (1 byte) gives 0x000000FF, 1 (2 bytes) gives 0x0000FFFF, and 2 or 3 (4 bytes) give 0xFFFFFFFF.
- R8: In type-0 mode, a device-select field of zero sets `err_flag` in the next cycle. Such an access is not forwarded, and a read gets the all-ones response of R7.
- R9: `cfg_subword` is 1 together with `cfg_valid` exactly when offset bits [1:0] are not zero. It is 0 in every other case.
- R10: `sts_abort_clr` pulses for one cycle together with each forwarded access, and at no other time.
- R11: `err_flag` stays set until reset. Accesses that come after the error are still translated normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_num | input | 8 | Static root bus number |
| map_we | input | 1 | Map register write strobe |
| map_wdata | input | 17 | Map value: [15:0] page, [16] non-type-0 mode |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Offset inside the configuration window |
| req_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 or 3 = 4 B |
| req_wdata | input | 32 | Write data |
| cfg_valid | output | 1 | Forwarded access strobe |
| cfg_write | output | 1 | Forwarded write flag |
| cfg_size | output | 2 | Forwarded size code |
| cfg_addr | output | 32 | Formed configuration address |
| cfg_wdata | output | 32 | Forwarded write data |
| cfg_subword | output | 1 | Forwarded access is not word aligned |
| sts_abort_clr | output | 1 | Pulse that clears the received-abort status bits |
| rsp_valid | output | 1 | Local read response strobe |
| rsp_data | output | 32 | Local read response data (all ones) |
| err_flag | output | 1 | Sticky empty device-select error |

## Verification
A wrong map register value shows up in the first access after the write. That access carries the wrong device, function or register field in `cfg_addr`, or it takes the wrong path: forwarded, dropped, or flagged as an error. A wrong encoder choice among several set device-select bits shows up as a wrong device field in that same cycle. A lost or stuck error state shows up at `err_flag` no later than the cycle after the faulty access. It also shows up on the first good access that follows, which must still be forwarded while the flag stays set. The local response and the abort-clear pulse are checked in the single cycle after each request, and again in the idle cycle after it, so a strobe that stays high one cycle too long is caught.

// File: rtl/cfgx_pkg.sv
`timescale 1ns/1ps
// Shared types for the configuration address translator.
package cfgx_pkg;

    localparam int CFG_DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        DEC_FORWARD = 2'd0,
        DEC_DROP    = 2'd1,
        DEC_FAULT   = 2'd2
    } xlate_dec_e;

    // All-ones read value for one access size; codes 2 and 3 are both full word
    function automatic logic [CFG_DATA_W-1:0] ones_for_size(acc_size_e sz);
        case (sz)
            SZ_BYTE: ones_for_size = CFG_DATA_W'(32'h0000_00FF);
            SZ_HALF: ones_for_size = CFG_DATA_W'(32'h0000_FFFF);
            default: ones_for_size = '1;
        endcase
    endfunction

endpackage

// File: rtl/cfgx_map_reg.sv
`timescale 1ns/1ps
// Map register. It holds the page value that supplies the upper half of
// the working address, plus the non-type-0 mode bit just above it.
// Assumes: writes are single-cycle strobes; reset is synchronous, active low.
module cfgx_map_reg #(
    parameter int MAP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [MAP_W:0]   wdata,
    output logic [MAP_W-1:0] page,
    output logic             type1
);

    logic [MAP_W:0] map_q;

    // Hold the map value; clear it to zero on reset
    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else if (we) map_q <= wdata;
    end

    assign page  = map_q[MAP_W-1:0];
    assign type1 = map_q[MAP_W];

endmodule

// File: rtl/cfgx_lsb_enc.sv
`timescale 1ns/1ps
// Lowest-set-bit encoder. Returns the index of the least significant 1 in
// vec, and whether any bit is set at all.
// Assumes: idx is meaningful only when any is 1.
module cfgx_lsb_enc #(
    parameter int IN_W  = 21,
    parameter int ENC_W = $clog2(IN_W)
) (
    input  logic [IN_W-1:0]  vec,
    output logic [ENC_W-1:0] idx,
    output logic             any
);

    logic [IN_W-1:0] seen_below;
    logic [IN_W-1:0] first;

    assign seen_below[0] = 1'b0;
    genvar gi;
    generate
        for (gi = 1; gi < IN_W; gi++) begin : g_chain
            assign seen_below[gi] = seen_below[gi-1] | vec[gi-1];
        end
    endgenerate

    assign first = vec & ~seen_below;
    assign any   = |vec;

    // Merge the single isolated bit position into a binary index
    always_comb begin
        idx = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (first[i]) idx = idx | ENC_W'(i);
        end
    end

endmodule

// File: rtl/cfgx_decode.sv
`timescale 1ns/1ps
// Combinational decode. It builds the working address, extracts the
// device, function and register fields, composes the configuration
// address, and picks forward, drop or fault.
// Assumes: page and type1 come from the map register; bus is static.
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int WIN_W     = 19,
    parameter int LOW_W     = 16,
    parameter int MAP_W     = 16,
    parameter int BUS_W     = 8,
    parameter int IDSEL_LSB = 11,
    parameter int FN_W      = 3,
    parameter int REG_W     = 8,
    parameter int DEV_W     = 5
) (
    input  logic [WIN_W-1:0]  req_addr,
    input  logic [MAP_W-1:0]  page,
    input  logic              type1,
    input  logic [BUS_W-1:0]  bus,
    output logic [31:0]       cfg_addr,
    output logic              subword,
    output xlate_dec_e        decision
);

    localparam int WORK_W  = LOW_W + MAP_W;
    localparam int IDSEL_W = WORK_W - IDSEL_LSB;
    localparam int ENC_W   = $clog2(IDSEL_W);
    localparam int PAD_W   = 32 - 1 - BUS_W - DEV_W - FN_W - REG_W;

    logic [WORK_W-1:0]  work;
    logic [IDSEL_W-1:0] idsel;
    logic [ENC_W-1:0]   dev_idx;
    logic               idsel_any;
    logic [DEV_W-1:0]   dev;
    logic [FN_W-1:0]    fn;
    logic [REG_W-1:0]   regno;
    logic               unused_win_hi;

    assign work          = {page, req_addr[LOW_W-1:0]};
    assign unused_win_hi = ^req_addr[WIN_W-1:LOW_W];
    assign idsel         = work[WORK_W-1:IDSEL_LSB];
    assign fn            = work[REG_W+FN_W-1:REG_W];
    assign regno         = work[REG_W-1:0];

    cfgx_lsb_enc #(
        .IN_W  (IDSEL_W),
        .ENC_W (ENC_W)
    ) u_enc (
        .vec (idsel),
        .idx (dev_idx),
        .any (idsel_any)
    );

    assign dev = DEV_W'(dev_idx);

    assign cfg_addr = {1'b1, {PAD_W{1'b0}}, bus, dev, fn, regno};
    assign subword  = |req_addr[1:0];

    // Decide the path: drop in non-type-0 mode, fault on empty select
    always_comb begin
        if (type1)           decision = DEC_DROP;
        else if (!idsel_any) decision = DEC_FAULT;
        else                 decision = DEC_FORWARD;
    end

endmodule

// File: rtl/cfgx_out_stage.sv
`timescale 1ns/1ps
// Output register stage. It turns a request and its decode into a
// one-cycle forward strobe or a local all-ones response, and keeps the
// sticky error flag.
// Assumes: req_valid is high for one cycle per access.
module cfgx_out_stage
    import cfgx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  acc_size_e             req_size,
    input  logic [CFG_DATA_W-1:0] req_wdata,
    input  logic [31:0]           addr_c,
    input  logic                  subword_c,
    input  xlate_dec_e            decision,
    output logic                  cfg_valid,
    output logic                  cfg_write,
    output logic [1:0]            cfg_size,
    output logic [31:0]           cfg_addr,
    output logic [CFG_DATA_W-1:0] cfg_wdata,
    output logic                  cfg_subword,
    output logic                  abort_clr,
    output logic                  rsp_valid,
    output logic [CFG_DATA_W-1:0] rsp_data,
    output logic                  err_flag
);

    logic fwd;
    logic local_rd;

    assign fwd      = req_valid && (decision == DEC_FORWARD);
    assign local_rd = req_valid && (decision != DEC_FORWARD) && !req_write;

    // Strobes: high for exactly one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid   <= 1'b0;
            abort_clr   <= 1'b0;
            rsp_valid   <= 1'b0;
            cfg_subword <= 1'b0;
        end else begin
            cfg_valid   <= fwd;
            abort_clr   <= fwd;
            rsp_valid   <= local_rd;
            cfg_subword <= fwd && subword_c;
        end
    end

    // Forwarded payload is captured on every forwarded access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_write <= 1'b0;
            cfg_size  <= 2'd0;
            cfg_addr  <= '0;
            cfg_wdata <= '0;
        end else if (fwd) begin
            cfg_write <= req_write;
            cfg_size  <= req_size;
            cfg_addr  <= addr_c;
            cfg_wdata <= req_wdata;
        end
    end

    // Local response data is all ones for the access size
    always_ff @(posedge clk) begin
        if (!rst_n)        rsp_data <= '0;
        else if (local_rd) rsp_data <= ones_for_size(req_size);
    end

    // Error flag is set by an empty device select and held until reset
    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else if (req_valid && decision == DEC_FAULT) err_flag <= 1'b1;
    end

endmodule

// File: rtl/cfg_addr_xlate.sv
`timescale 1ns/1ps
// Type-0 PCI configuration address translator. It maps a window access
// plus a programmable page onto a root-bus configuration address with a
// one-hot-to-binary device encode, one register stage at the output.
// Assumes: bus_num is static; one request per req_valid cycle.
module cfg_addr_xlate
    import cfgx_pkg::*;
#(
    parameter int WIN_W     = 19,
    parameter int LOW_W     = 16,
    parameter int MAP_W     = 16,
    parameter int BUS_W     = 8,
    parameter int IDSEL_LSB = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_num,
    input  logic              map_we,
    input  logic [MAP_W:0]    map_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [WIN_W-1:0]  req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              cfg_valid,
    output logic              cfg_write,
    output logic [1:0]        cfg_size,
    output logic [31:0]       cfg_addr,
    output logic [31:0]       cfg_wdata,
    output logic              cfg_subword,
    output logic              sts_abort_clr,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              err_flag
);

    logic [MAP_W-1:0] map_page;
    logic             map_type1;
    logic [31:0]      addr_c;
    logic             subword_c;
    xlate_dec_e       decision;

    cfgx_map_reg #(.MAP_W(MAP_W)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (map_we),
        .wdata (map_wdata),
        .page  (map_page),
        .type1 (map_type1)
    );

    cfgx_decode #(
        .WIN_W     (WIN_W),
        .LOW_W     (LOW_W),
        .MAP_W     (MAP_W),
        .BUS_W     (BUS_W),
        .IDSEL_LSB (IDSEL_LSB)
    ) u_dec (
        .req_addr (req_addr),
        .page     (map_page),
        .type1    (map_type1),
        .bus      (bus_num),
        .cfg_addr (addr_c),
        .subword  (subword_c),
        .decision (decision)
    );

    cfgx_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_size    (acc_size_e'(req_size)),
        .req_wdata   (req_wdata),
        .addr_c      (addr_c),
        .subword_c   (subword_c),
        .decision    (decision),
        .cfg_valid   (cfg_valid),
        .cfg_write   (cfg_write),
        .cfg_size    (cfg_size),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_subword (cfg_subword),
        .abort_clr   (sts_abort_clr),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .err_flag    (err_flag)
    );

endmodule

// File: rtl/cfgx_checker.sv
`timescale 1ns/1ps
// Protocol checker for the translator, attached by bind.
module cfgx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        map_type1,
    input logic        cfg_valid,
    input logic [31:0] cfg_addr,
    input logic        cfg_subword,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        err_flag
);

    p_one_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && rsp_valid));

    p_addr_format_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (cfg_addr[31] && cfg_addr[30:24] == 7'd0));

    p_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(req_valid));

    p_type1_no_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_type1) |=> !cfg_valid);

    p_write_no_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    p_ones_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data == 32'h0000_00FF || rsp_data == 32'h0000_FFFF
                       || rsp_data == 32'hFFFF_FFFF));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_subword_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_subword |-> (cfg_valid && cfg_addr[1:0] != 2'd0));

endmodule

bind cfg_addr_xlate cfgx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .map_type1   (map_type1),
    .cfg_valid   (cfg_valid),
    .cfg_addr    (cfg_addr),
    .cfg_subword (cfg_subword),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .err_flag    (err_flag)
);

// File: tb/test_cfg_addr_xlate.sv
`timescale 1ns/1ps
module test_cfg_addr_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_num = 8'h00;
    logic        map_we = 1'b0;
    logic [16:0] map_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        cfg_valid, cfg_write, cfg_subword, sts_abort_clr, rsp_valid, err_flag;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_addr, cfg_wdata, rsp_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    cfg_addr_xlate i_cfg_addr_xlate (
        .clk(clk), .rst_n(rst_n), .bus_num(bus_num),
        .map_we(map_we), .map_wdata(map_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_size(cfg_size),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_subword(cfg_subword),
        .sts_abort_clr(sts_abort_clr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [7:0] bus, input int dev,
                                             input int fn, input logic [7:0] rg);
        return 32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11) | (32'(fn) << 8) | 32'(rg);
    endfunction

    task automatic set_map(input logic [16:0] v);
        @(negedge clk);
        map_we = 1'b1; map_wdata = v;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    // Drive one request; on return the registered outputs for it are visible
    task automatic access(input logic w, input logic [18:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk({req, " strobe drops"}, {29'd0, cfg_valid, sts_abort_clr, rsp_valid}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R6 reset cfg_valid", {31'd0, cfg_valid}, 32'd0);
        chk("R6 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R8 reset err_flag", {31'd0, err_flag}, 32'd0);
        chk("R10 reset abort_clr", {31'd0, sts_abort_clr}, 32'd0);
    endtask

    task automatic t_map_reset_zero;
        bus_num = 8'h3C;
        access(1'b0, 19'h00800, 2'd2, 32'h0);
        chk("R1 map resets to zero", cfg_addr, exp_addr(8'h3C, 0, 0, 8'h00));
        chk("R6 strobe after reset map", {31'd0, cfg_valid}, 32'd1);
    endtask

    task automatic t_translate;
        set_map(17'h0_0040);
        access(1'b1, 19'h70534, 2'd2, 32'hDEAD_BEEF);
        chk("R2/R3 page and ignored high offset", cfg_addr, exp_addr(8'h3C, 11, 5, 8'h34));
        chk("R6 write flag", {31'd0, cfg_write}, 32'd1);
        chk("R6 write data", cfg_wdata, 32'hDEAD_BEEF);
        chk("R6 size code", {30'd0, cfg_size}, 32'd2);
        chk("R10 abort clear pulse", {31'd0, sts_abort_clr}, 32'd1);
        chk("R9 aligned not subword", {31'd0, cfg_subword}, 32'd0);
        chk("R7 no local response", {31'd0, rsp_valid}, 32'd0);
        idle_check("R10");
    endtask

    task automatic t_lowest_bit;
        access(1'b0, 19'h00A34, 2'd2, 32'h0);
        chk("R3 lowest set bit wins", cfg_addr, exp_addr(8'h3C, 0, 2, 8'h34));
        chk("R4 read flag", {31'd0, cfg_write}, 32'd0);
    endtask

    task automatic t_top_bit;
        bus_num = 8'h05;
        set_map(17'h0_8000);
        access(1'b0, 19'h000FC, 2'd2, 32'h0);
        chk("R5 top select bit and bus", cfg_addr, exp_addr(8'h05, 20, 0, 8'hFC));
    endtask

    task automatic t_subword;
        set_map(17'h0_0040);
        access(1'b1, 19'h00536, 2'd1, 32'h0000_1234);
        chk("R9 subword flagged", {31'd0, cfg_subword}, 32'd1);
        chk("R4 register low bits kept", cfg_addr, exp_addr(8'h05, 11, 5, 8'h36));
        chk("R6 half size code", {30'd0, cfg_size}, 32'd1);
    endtask

    task automatic t_type1;
        set_map(17'h1_0040);
        access(1'b0, 19'h00534, 2'd0, 32'h0);
        chk("R7 byte read ones", rsp_data, 32'h0000_00FF);
        chk("R7 read response strobe", {31'd0, rsp_valid}, 32'd1);
        chk("R7 not forwarded", {31'd0, cfg_valid}, 32'd0);
        chk("R10 no abort clear when dropped", {31'd0, sts_abort_clr}, 32'd0);
        access(1'b0, 19'h00534, 2'd1, 32'h0);
        chk("R7 half read ones", rsp_data, 32'h0000_FFFF);
        access(1'b0, 19'h00534, 2'd2, 32'h0);
        chk("R7 word read ones", rsp_data, 32'hFFFF_FFFF);
        access(1'b1, 19'h00534, 2'd2, 32'h5555_5555);
        chk("R7 write dropped", {30'd0, cfg_valid, rsp_valid}, 32'd0);
        chk("R8 no error in drop mode", {31'd0, err_flag}, 32'd0);
    endtask

    task automatic t_fault;
        set_map(17'h0_0000);
        access(1'b0, 19'h00700, 2'd2, 32'h0);
        chk("R8 error raised", {31'd0, err_flag}, 32'd1);
        chk("R8 fault read ones", rsp_data, 32'hFFFF_FFFF);
        chk("R8 fault not forwarded", {31'd0, cfg_valid}, 32'd0);
        access(1'b1, 19'h00700, 2'd2, 32'h0);
        chk("R8 fault write silent", {30'd0, cfg_valid, rsp_valid}, 32'd0);
        set_map(17'h0_0002);
        access(1'b0, 19'h00100, 2'd2, 32'h0);
        chk("R11 later access translated", cfg_addr, exp_addr(8'h05, 6, 1, 8'h00));
        chk("R11 forwarded after error", {31'd0, cfg_valid}, 32'd1);
        chk("R11 error stays set", {31'd0, err_flag}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_reset_zero();
        t_translate();
        t_lowest_bit();
        t_top_bit();
        t_subword();
        t_type1();
        t_fault();
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule